// File: doc/BRIEF.md
# Port I/O Transfer Sequencer

This block carries out input and output operations against a port space that is kept apart from memory. The port space holds 65536 byte-wide ports. A command selects one of two kinds of operation. A single-item transfer moves one byte, word or doubleword between a data register and a port. A block transfer moves a run of items between one port and consecutive memory locations.

A block transfer steps its memory pointer after every item and counts a repeat count down to zero. Every command passes an access check before any bus cycle. In protected mode, a caller whose privilege level is numerically above the I/O privilege level is checked against a per-port deny lookup. That lookup sits outside the block: the block presents a port number, and gets back one deny bit for each of the four bytes that start at that port.

The block drives a port bus and a memory bus, each with single-cycle strobes. When a command is refused, the block raises a fault pulse and leaves its pointer and count untouched.

Top module: `pio_seq`

## Requirements
- R1: While reset is held, and after it is released with no command, `busy`, `done`, `fault` and all four strobes are low.
- R2: A single-item transfer takes its port from `imm_port`, zero-extended, when `use_imm`=1, and from the 16-bit `port_reg` otherwise. A block transfer always uses `port_reg`.
- R3: The size code is 0 for a byte, 1 for a word, and 2 or 3 for a doubleword. `io_be` bit i is 1 when lane i falls inside [off, off+n), where off is port bits [1:0] and n is the item size in bytes. Lanes past lane 3 are dropped. Write data byte k goes to lane off+k. Read data from lane off+k is returned right-justified in byte k.
- R4: A single-item transfer is accepted by the clock edge that samples `start`. Its port strobe (`io_rd` when `is_out`=0, `io_wr` when `is_out`=1) is high in the second cycle after that edge. In the cycle after the strobe, `done` pulses, and for an input `reg_rdata` holds the result.
- R5: Each item of an output block transfer is a `mem_rd` cycle at the current pointer, followed at once by an `io_wr` cycle that carries that memory data. The pointer is loaded from `src_ptr`.
- R6: Each item of an input block transfer is an `io_rd` cycle, followed at once by a `mem_wr` cycle at the current pointer. The pointer is loaded from `dst_ptr`.
- R7: After each block item, the pointer grows by n when `dir_down`=0 and shrinks by n when `dir_down`=1. The result is visible on `cur_ptr`.
- R8: A block transfer performs `rep_count` items. Then `done` pulses for one cycle and `cur_cnt` reads 0. With `rep_count`=0, `done` pulses in the second cycle after the start edge and no strobe is raised.
- R9: The block faults a block transfer of words at an odd port, and a block transfer of doublewords at a port that is not a multiple of 4.
- R10: With `prot_mode`=0, no port is refused, whatever the deny bits and privilege levels.
- R11: With `prot_mode`=1 and `cpl`<=`iopl`, every port is allowed. With `cpl`>`iopl`, the access is refused if `perm_deny` bit i is 1 for any i<n.
- R12: A refused command gives a single-cycle `fault` pulse in the second cycle after the start edge. It raises no strobe, and `cur_ptr` and `cur_cnt` keep the values loaded with the command.
- R13: A `start` seen while `busy` is high is ignored, and the running command finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command request, sampled while idle |
| is_block | input | 1 | 1 selects a block transfer |
| is_out | input | 1 | 1 selects the output direction (towards the port) |
| use_imm | input | 1 | Single-item transfer takes its port from the immediate |
| size | input | 2 | Item size code |
| dir_down | input | 1 | Block pointer steps downward |
| imm_port | input | 8 | Immediate port number |
| port_reg | input | PORT_W | Port register value |
| src_ptr | input | MEM_AW | Source memory pointer |
| dst_ptr | input | MEM_AW | Destination memory pointer |
| rep_count | input | CNT_W | Number of block items |
| reg_wdata | input | DATA_W | Register data for a single-item output |
| prot_mode | input | 1 | Protected mode enables the access check |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| perm_port | output | PORT_W | Port presented to the deny lookup |
| perm_deny | input | DATA_W/8 | Deny bit for each of the bytes that start at perm_port |
| io_addr | output | PORT_W | Port bus address |
| io_be | output | DATA_W/8 | Port bus byte enables |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | DATA_W | Port write data, lane-steered |
| io_rdata | input | DATA_W | Port read data, lane-steered |
| mem_addr | output | MEM_AW | Memory address |
| mem_size | output | 2 | Memory item size code |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data, right-justified |
| mem_rdata | input | DATA_W | Memory read data, right-justified |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Refusal pulse |
| reg_rdata | output | DATA_W | Result of a single-item input |
| cur_ptr | output | MEM_AW | Current memory pointer |
| cur_cnt | output | CNT_W | Items remaining |

## Verification
The bench drives unaligned single-item transfers, including a doubleword whose upper lanes run past lane 3. A design with wrong lane steering would put data in the wrong lanes or raise enables beyond the bus. Block runs step both upward and downward with byte, word and doubleword items. A sign error or a fixed one-byte step would leave `cur_ptr` wrong at the end.

The deny lookup is tried in three cases: a deny bit on a byte that only a wider item covers, the same access in real mode, and the same access with sufficient privilege. A check that looks only at the first byte, or that ignores the mode or the privilege levels, would allow or refuse the wrong access. The bench also sends a repeat count of zero, misaligned block ports, and a second `start` issued in the middle of a block. Any of these, handled wrongly, shows up as a stray strobe, a missing pulse, or a changed sequence.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_REG   = 3'd2,
        ST_PA    = 3'd3,
        ST_PB    = 3'd4
    } seq_st_e;

    // Item size in bytes for a size code (2 and 3 both mean four bytes).
    function automatic logic [2:0] item_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pio_seq_gate.sv
module pio_seq_gate #(
    parameter int LANES = 4
) (
    input  logic             prot_mode,
    input  logic [1:0]       cpl,
    input  logic [1:0]       iopl,
    input  logic             is_block,
    input  logic [1:0]       size,
    input  logic [1:0]       port_lo,
    input  logic [LANES-1:0] deny,
    output logic             allow
);
    import pio_seq_pkg::*;

    logic [LANES-1:0] covered;
    logic             deny_hit;
    logic             priv_ok;
    logic             align_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_cover
        assign covered[i] = (32'(i) < 32'(item_bytes(size)));
    end

    assign deny_hit = |(deny & covered);
    assign priv_ok  = !prot_mode || (cpl <= iopl) || !deny_hit;

    always_comb begin
        if (!is_block || size == 2'd0) begin
            align_ok = 1'b1;
        end else if (size == 2'd1) begin
            align_ok = !port_lo[0];
        end else begin
            align_ok = (port_lo == 2'b00);
        end
    end

    assign allow = priv_ok && align_ok;

endmodule

// File: rtl/pio_seq_lanes.sv
module pio_seq_lanes #(
    parameter  int LANES = 4,
    localparam int LB    = $clog2(LANES)
) (
    input  logic [1:0]         size,
    input  logic [LB-1:0]      off,
    input  logic [8*LANES-1:0] wsrc,
    input  logic [8*LANES-1:0] rraw,
    output logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] wlanes,
    output logic [8*LANES-1:0] rjust
);
    import pio_seq_pkg::*;

    logic [LB:0] nb;
    assign nb = (LB+1)'(item_bytes(size));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LB:0] rel;
        logic [LB:0] src_i;
        logic        hit;
        logic        rok;

        // write side: lane i carries source byte (i - off)
        assign rel    = (LB+1)'(i) - {1'b0, off};
        assign hit    = ((LB+1)'(i) >= {1'b0, off}) && (rel < nb);
        assign be[i]  = hit;
        assign wlanes[8*i +: 8] = hit ? wsrc[8*rel[LB-1:0] +: 8] : 8'h00;

        // read side: result byte i comes from lane (i + off)
        assign src_i  = (LB+1)'(i) + {1'b0, off};
        assign rok    = ((LB+1)'(i) < nb) && !src_i[LB];
        assign rjust[8*i +: 8] = rok ? rraw[8*src_i[LB-1:0] +: 8] : 8'h00;
    end

endmodule

// File: rtl/pio_seq.sv
module pio_seq #(
    parameter  int PORT_W = 16,
    parameter  int MEM_AW = 16,
    parameter  int CNT_W  = 16,
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LB     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_block,
    input  logic              is_out,
    input  logic              use_imm,
    input  logic [1:0]        size,
    input  logic              dir_down,
    input  logic [7:0]        imm_port,
    input  logic [PORT_W-1:0] port_reg,
    input  logic [MEM_AW-1:0] src_ptr,
    input  logic [MEM_AW-1:0] dst_ptr,
    input  logic [CNT_W-1:0]  rep_count,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              prot_mode,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    output logic [PORT_W-1:0] perm_port,
    input  logic [LANES-1:0]  perm_deny,
    output logic [PORT_W-1:0] io_addr,
    output logic [LANES-1:0]  io_be,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [MEM_AW-1:0] cur_ptr,
    output logic [CNT_W-1:0]  cur_cnt
);
    import pio_seq_pkg::*;

    typedef struct packed {
        seq_st_e           st;
        logic              blk;
        logic              out;
        logic [1:0]        sz;
        logic              down;
        logic [PORT_W-1:0] port;
        logic [MEM_AW-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              fault;
    } seq_t;

    seq_t q, d;

    logic              allow;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_w;
    logic [DATA_W-1:0] lane_r;
    logic [MEM_AW-1:0] step;

    pio_seq_gate #(.LANES(LANES)) u_gate (
        .prot_mode (prot_mode),
        .cpl       (cpl),
        .iopl      (iopl),
        .is_block  (q.blk),
        .size      (q.sz),
        .port_lo   (q.port[1:0]),
        .deny      (perm_deny),
        .allow     (allow)
    );

    pio_seq_lanes #(.LANES(LANES)) u_lanes (
        .size   (q.sz),
        .off    (q.port[LB-1:0]),
        .wsrc   (q.hold),
        .rraw   (io_rdata),
        .be     (lane_be),
        .wlanes (lane_w),
        .rjust  (lane_r)
    );

    assign step = MEM_AW'(item_bytes(q.sz));

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fault = 1'b0;
        io_rd   = 1'b0;
        io_wr   = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_CHECK;
                    d.blk  = is_block;
                    d.out  = is_out;
                    d.sz   = size;
                    d.down = dir_down;
                    d.port = (!is_block && use_imm) ? PORT_W'(imm_port) : port_reg;
                    d.ptr  = is_out ? src_ptr : dst_ptr;
                    d.cnt  = rep_count;
                    d.hold = reg_wdata;
                end
            end
            ST_CHECK: begin
                if (!allow) begin
                    d.fault = 1'b1;
                    d.st    = ST_IDLE;
                end else if (q.blk && q.cnt == '0) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = q.blk ? ST_PA : ST_REG;
                end
            end
            ST_REG: begin
                io_rd  = !q.out;
                io_wr  = q.out;
                if (!q.out) begin
                    d.rdata = lane_r;
                end
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            ST_PA: begin
                if (q.out) begin
                    mem_rd = 1'b1;
                    d.hold = mem_rdata;
                end else begin
                    io_rd  = 1'b1;
                    d.hold = lane_r;
                end
                d.st = ST_PB;
            end
            ST_PB: begin
                io_wr  = q.out;
                mem_wr = !q.out;
                d.ptr  = q.down ? (q.ptr - step) : (q.ptr + step);
                d.cnt  = q.cnt - 1'b1;
                if (q.cnt == CNT_W'(1)) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = ST_PA;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign perm_port = q.port;
    assign io_addr   = q.port;
    assign io_be     = lane_be;
    assign io_wdata  = lane_w;
    assign mem_addr  = q.ptr;
    assign mem_size  = q.sz;
    assign mem_wdata = q.hold;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fault     = q.fault;
    assign reg_rdata = q.rdata;
    assign cur_ptr   = q.ptr;
    assign cur_cnt   = q.cnt;

endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
    parameter int MEM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              io_rd,
    input logic              io_wr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [MEM_AW-1:0] cur_ptr
);

    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !busy);

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({io_rd, io_wr, mem_rd, mem_wr}) <= 1);

    // R5
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> io_wr);

    // R6
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(io_rd));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R12
    fault_keep_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && cur_ptr == $past(cur_ptr)));

endmodule

bind pio_seq pio_seq_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .fault   (fault),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .cur_ptr (cur_ptr)
);

// File: tb/pio_seq_bench.sv
module pio_seq_bench;
    localparam int CLK_NS = 10;
    localparam int K_NONE = 0, K_IORD = 1, K_IOWR = 2, K_MRD = 3, K_MWR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_block = 1'b0, is_out = 1'b0, use_imm = 1'b0, dir_down = 1'b0;
    logic [1:0]  size = 2'd0, cpl = 2'd0, iopl = 2'd0;
    logic        prot_mode = 1'b0;
    logic [7:0]  imm_port = 8'h00;
    logic [15:0] port_reg = 16'h0, src_ptr = 16'h0, dst_ptr = 16'h0, rep_count = 16'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [15:0] perm_port, io_addr, mem_addr, cur_ptr, cur_cnt;
    logic [3:0]  perm_deny, io_be;
    logic        io_rd, io_wr, mem_rd, mem_wr, busy, done, fault;
    logic [31:0] io_wdata, io_rdata, mem_wdata, mem_rdata, reg_rdata;
    logic [1:0]  mem_size;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction
    function automatic logic [31:0] iof(input logic [15:0] a);
        return {~a, a ^ 16'h0F0F};
    endfunction
    function automatic bit deny_byte(input logic [15:0] p);
        return (p == 16'h0071) || (p == 16'h0302) || (p == 16'h8003);
    endfunction
    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction
    function automatic logic [3:0] exp_be(input logic [1:0] sz, input int off);
        logic [3:0] r = 4'h0;
        for (int k = 0; k < nbytes(sz); k++) if (off + k < 4) r[off+k] = 1'b1;
        return r;
    endfunction
    function automatic logic [31:0] steer_w(input logic [31:0] v, input logic [1:0] sz, input int off);
        logic [31:0] r = 32'h0;
        for (int k = 0; k < nbytes(sz); k++) if (off + k < 4) r[8*(off+k) +: 8] = v[8*k +: 8];
        return r;
    endfunction
    function automatic logic [31:0] steer_r(input logic [31:0] v, input logic [1:0] sz, input int off);
        logic [31:0] r = 32'h0;
        for (int k = 0; k < nbytes(sz); k++) if (off + k < 4) r[8*k +: 8] = v[8*(off+k) +: 8];
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < 4; i++) perm_deny[i] = deny_byte(perm_port + 16'(i));
    end
    assign io_rdata  = iof(io_addr);
    assign mem_rdata = memf(mem_addr);

    pio_seq u_pio_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_block(is_block), .is_out(is_out),
        .use_imm(use_imm), .size(size), .dir_down(dir_down), .imm_port(imm_port),
        .port_reg(port_reg), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .rep_count(rep_count),
        .reg_wdata(reg_wdata), .prot_mode(prot_mode), .cpl(cpl), .iopl(iopl),
        .perm_port(perm_port), .perm_deny(perm_deny), .io_addr(io_addr), .io_be(io_be),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .fault(fault), .reg_rdata(reg_rdata), .cur_ptr(cur_ptr), .cur_cnt(cur_cnt)
    );

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic see(input string req, input bit e_busy, input bit e_done, input bit e_fault,
                       input int kind, input logic [15:0] e_addr, input logic [3:0] e_be,
                       input logic [31:0] e_data);
        logic [3:0] e_str;
        e_str = (kind == K_IORD) ? 4'b1000 : (kind == K_IOWR) ? 4'b0100 :
                (kind == K_MRD)  ? 4'b0010 : (kind == K_MWR)  ? 4'b0001 : 4'b0000;
        cmp(req, "busy", 32'(busy), 32'(e_busy));
        cmp(req, "done", 32'(done), 32'(e_done));
        cmp(req, "fault", 32'(fault), 32'(e_fault));
        cmp(req, "strobes", 32'({io_rd, io_wr, mem_rd, mem_wr}), 32'(e_str));
        if (kind == K_IORD || kind == K_IOWR) begin
            cmp(req, "io_addr", 32'(io_addr), 32'(e_addr));
            cmp(req, "io_be", 32'(io_be), 32'(e_be));
        end
        if (kind == K_IOWR) cmp(req, "io_wdata", io_wdata, e_data);
        if (kind == K_MRD || kind == K_MWR) cmp(req, "mem_addr", 32'(mem_addr), 32'(e_addr));
        if (kind == K_MWR) cmp(req, "mem_wdata", mem_wdata, e_data);
    endtask

    task automatic run_cmd(input string req, input bit blk, input bit outd, input bit imm,
                           input logic [1:0] sz, input logic [7:0] ip, input logic [15:0] pr,
                           input logic [15:0] sp, input logic [15:0] dp, input logic [15:0] rc,
                           input bit dn, input bit pm, input logic [1:0] cl, input logic [1:0] il,
                           input logic [31:0] wd, input bit poke);
        logic [15:0] port, ptr;
        int off, n;
        bit mis, den;
        port = blk ? pr : (imm ? {8'h00, ip} : pr);
        n    = nbytes(sz);
        off  = int'(port[1:0]);
        mis  = blk && ((sz == 2'd1 && port[0]) || (sz >= 2'd2 && port[1:0] != 2'b00));
        den  = 1'b0;
        for (int k = 0; k < n; k++) if (deny_byte(port + 16'(k))) den = 1'b1;
        den  = den && pm && (cl > il);
        ptr  = outd ? sp : dp;

        @(negedge clk);
        is_block = blk; is_out = outd; use_imm = imm; size = sz; imm_port = ip; port_reg = pr;
        src_ptr = sp; dst_ptr = dp; rep_count = rc; dir_down = dn; prot_mode = pm;
        cpl = cl; iopl = il; reg_wdata = wd; start = 1'b1;
        @(negedge clk);
        see(req, 1, 0, 0, K_NONE, 0, 0, 0);
        start = 1'b0;
        @(negedge clk);
        if (mis || den) begin
            see(req, 0, 0, 1, K_NONE, 0, 0, 0);
            cmp(req, "cur_ptr kept", 32'(cur_ptr), 32'(ptr));
            cmp(req, "cur_cnt kept", 32'(cur_cnt), 32'(rc));
        end else if (!blk) begin
            see(req, 1, 0, 0, outd ? K_IOWR : K_IORD, port, exp_be(sz, off), steer_w(wd, sz, off));
            @(negedge clk);
            see(req, 0, 1, 0, K_NONE, 0, 0, 0);
            if (!outd) cmp(req, "reg_rdata", reg_rdata, steer_r(iof(port), sz, off));
        end else if (rc == 16'h0) begin
            see(req, 0, 1, 0, K_NONE, 0, 0, 0);
        end else begin
            for (int k = 0; k < int'(rc); k++) begin
                if (outd) see(req, 1, 0, 0, K_MRD, ptr, 0, 0);
                else      see(req, 1, 0, 0, K_IORD, port, exp_be(sz, off), 0);
                if (poke && k == 0) begin
                    start = 1'b1; port_reg = 16'hBEEF; rep_count = 16'd7; is_out = ~outd;
                end
                @(negedge clk);
                start = 1'b0;
                if (outd) see(req, 1, 0, 0, K_IOWR, port, exp_be(sz, off), steer_w(memf(ptr), sz, off));
                else      see(req, 1, 0, 0, K_MWR, ptr, 0, steer_r(iof(port), sz, off));
                ptr = dn ? ptr - 16'(n) : ptr + 16'(n);
                @(negedge clk);
            end
            see(req, 0, 1, 0, K_NONE, 0, 0, 0);
            cmp(req, "cur_ptr final", 32'(cur_ptr), 32'(ptr));
            cmp(req, "cur_cnt final", 32'(cur_cnt), 32'h0);
        end
        @(negedge clk);
        see(req, 0, 0, 0, K_NONE, 0, 0, 0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        see("R1", 0, 0, 0, K_NONE, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        see("R1", 0, 0, 0, K_NONE, 0, 0, 0);

        // R2 R4: immediate port, byte input, port_reg holds something else
        run_cmd("R2_R4", 0, 0, 1, 2'd0, 8'hF0, 16'h1234, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2 R3: register port, unaligned word output
        run_cmd("R2_R3", 0, 1, 0, 2'd1, 8'h11, 16'h1235, 0, 0, 0, 0, 0, 0, 0, 32'hCAFE_8899, 0);
        // R3: dword input truncated at lane 3
        run_cmd("R3", 0, 0, 0, 2'd2, 8'h00, 16'h2002, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 R4: dword output at aligned port, size code 3
        run_cmd("R3_R4", 0, 1, 1, 2'd3, 8'h40, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 32'h0102_0304, 0);
        // R5 R7 R8: byte block output, pointer upward
        run_cmd("R5_R7", 1, 1, 0, 2'd0, 8'h00, 16'h0043, 16'h1000, 16'h9999, 16'd3, 0, 0, 0, 0, 0, 0);
        // R6 R7: word block input, pointer downward
        run_cmd("R6_R7", 1, 0, 0, 2'd1, 8'h00, 16'h0100, 16'h9999, 16'h2000, 16'd2, 1, 0, 0, 0, 0, 0);
        // R13 R6: dword block input with a start pulse mid-run
        run_cmd("R13", 1, 0, 0, 2'd2, 8'h00, 16'h0200, 16'h0000, 16'h3000, 16'd2, 0, 0, 0, 0, 0, 1);
        // R8: zero repeat count
        run_cmd("R8", 1, 1, 0, 2'd1, 8'h00, 16'h0400, 16'h4000, 16'h0000, 16'd0, 0, 0, 0, 0, 0, 0);
        // R9: misaligned word and dword blocks
        run_cmd("R9", 1, 0, 0, 2'd1, 8'h00, 16'h0101, 16'h0000, 16'h5000, 16'd2, 0, 0, 0, 0, 0, 0);
        run_cmd("R9", 1, 1, 0, 2'd2, 8'h00, 16'h0202, 16'h5100, 16'h0000, 16'd1, 0, 0, 0, 0, 0, 0);
        // R11 R12: deny bit on the second byte of a word
        run_cmd("R11_R12", 0, 0, 0, 2'd1, 8'h00, 16'h0070, 0, 0, 0, 0, 1, 2'd3, 2'd0, 0, 0);
        // R10: the same access in real mode
        run_cmd("R10", 0, 0, 0, 2'd1, 8'h00, 16'h0070, 0, 0, 0, 0, 0, 2'd3, 2'd0, 0, 0);
        // R11: sufficient privilege
        run_cmd("R11", 0, 0, 0, 2'd1, 8'h00, 16'h0070, 0, 0, 0, 0, 1, 2'd0, 2'd0, 0, 0);
        // R11: byte not covering the denied port
        run_cmd("R11", 0, 0, 1, 2'd0, 8'h70, 16'h0000, 0, 0, 0, 0, 1, 2'd3, 2'd0, 0, 0);
        // R12: denied dword block, pointer and count kept
        run_cmd("R12", 1, 1, 0, 2'd2, 8'h00, 16'h0300, 16'h6000, 16'h0000, 16'd4, 0, 1, 2'd2, 2'd1, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule